// File: doc/BRIEF.md
# Clock Synthesizer Divider Configuration Loader

This block holds the programming state of a clock synthesizer: a feedback divide value, an output divide code and a two-bit test selector. The values arrive through one of two paths. A parallel path copies the divide pins whenever its active-low load pin is low, and freezes them when that pin rises. A three-wire serial path (shift clock, shift data, load strobe) fills a shift register and moves it into the same output latches. The latched divide values drive the divider logic. A registered test output, chosen by the test selector, shows a constant low, the serial data line or the feedback divider output.

All control and data pins are treated as asynchronous to a free-running system clock. They pass through a synchronizer chain of `SYNC_STAGES` flops before the block acts on them. Edges on the serial shift clock are found in the system clock domain. As a result, every output responds `SYNC_STAGES + 1` system clocks after the pin change that caused it. The values on the parallel pins while reset is held become the power-up divide setting.

Top module: `clk_cfg_loader`

## Requirements
- R1: While `rst` is high, `m_out`/`n_out` load the current `par_m`/`par_n` pins, the test selector clears to 00 and `test_out` is 0.
- R2: While the synchronized `par_load_n` is 0, `m_out`/`n_out` follow `par_m`/`par_n`. The delay is `SYNC_STAGES + 1` clocks.
- R3: After `par_load_n` rises, `m_out`/`n_out` keep the last pin values, even when the pins change. This holds until a serial load or a new low on `par_load_n`.
- R4: While `par_load_n` is 1, each rising edge of `ser_clk` shifts `ser_data` into a 14-bit register. The first bit shifted becomes the test selector MSB. The frame order, first to last, is selector bits 1 and 0, `n` bits 2..0, then `m` bits 8..0.
- R5: A high level on `ser_load` (with `par_load_n` high) transfers the shift register into the selector, `n_out` and `m_out`.
- R6: While `ser_load` is low and `par_load_n` is high, the outputs and the selector hold, even while frames are being shifted.
- R7: While `ser_load` stays high, each `ser_clk` rising edge passes the newly shifted register contents straight to the outputs.
- R8: In serial mode, `test_out` depends on the selector. Code 00 gives 0, 01 gives `ser_data`, 10 gives `fb_div`, and the reserved code 11 gives 0.
- R9: While `par_load_n` is 0, `test_out` is 0. The selector keeps its value through parallel mode.
- R10: A new low on `par_load_n` after a serial load replaces the serially loaded divide values with the pin values.
- R11: `ser_clk` edges while `par_load_n` is 0 do not shift, so the shift register keeps its earlier contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| par_load_n | input | 1 | Parallel load enable, active low; its rising edge freezes the pin values |
| par_m | input | M_W | Parallel feedback divide value |
| par_n | input | N_W | Parallel output divide code |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data |
| ser_load | input | 1 | Serial load strobe, transparent while high |
| fb_div | input | 1 | Feedback divider output, routed to the test output |
| m_out | output | M_W | Latched feedback divide value |
| n_out | output | N_W | Latched output divide code |
| test_out | output | 1 | Registered test output |

## Verification
The bench builds the block with the default 9-bit and 3-bit divide fields and sets `SYNC_STAGES` to 3 instead of 2. The deeper chain stretches the pin-to-output delay and shows that the synchronizer depth is honoured everywhere. The bench's queue-based reference model takes its delay from that same parameter. With full-width fields, the bench can use all-ones values such as 511. It also checks a partly shifted frame whose bits straddle the selector, `n` and `m` fields, so the field boundaries are tested.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  // Test output selector codes carried in the first two serial bits.
  typedef enum logic [1:0] {
    TSEL_LOW   = 2'b00,
    TSEL_SDATA = 2'b01,
    TSEL_FBDIV = 2'b10,
    TSEL_RSVD  = 2'b11
  } tsel_e;

  localparam int TSEL_W = 2;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_sync
);

  logic [W-1:0] chain [STAGES];

  // During reset every stage loads the live pins, so the chain leaves
  // reset already settled on the power-up values.
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          chain[0] <= d_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= d_in;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign d_sync = chain[STAGES-1];

endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
  parameter int FW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shift_en,
  input  logic          bit_in,
  output logic [FW-1:0] frame_nx
);

  logic [FW-1:0] frame_q;

  // First bit in ends in the MSB after a full frame.
  always_comb begin
    frame_nx = frame_q;
    if (shift_en) frame_nx = {frame_q[FW-2:0], bit_in};
  end

  always_ff @(posedge clk) begin
    if (rst) frame_q <= '0;
    else     frame_q <= frame_nx;
  end

endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import cfg_loader_pkg::*;
#(
  parameter int M_W = 9,
  parameter int N_W = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [M_W-1:0]          rst_m,
  input  logic [N_W-1:0]          rst_n,
  input  logic                    par_mode,
  input  logic                    ser_ld,
  input  logic [M_W-1:0]          pin_m,
  input  logic [N_W-1:0]          pin_n,
  input  logic [TSEL_W+N_W+M_W-1:0] frame,
  output logic [M_W-1:0]          m_q,
  output logic [N_W-1:0]          n_q,
  output logic [TSEL_W-1:0]       tsel_q
);

  localparam int FW = TSEL_W + N_W + M_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      m_q    <= rst_m;
      n_q    <= rst_n;
      tsel_q <= TSEL_LOW;
    end else if (par_mode) begin
      // transparent parallel path; the rising edge of the load pin
      // simply stops this branch, leaving the last pin values latched
      m_q <= pin_m;
      n_q <= pin_n;
    end else if (ser_ld) begin
      tsel_q <= frame[FW-1 -: TSEL_W];
      n_q    <= frame[M_W +: N_W];
      m_q    <= frame[M_W-1:0];
    end
  end

endmodule

// File: rtl/cfg_test_mux.sv
module cfg_test_mux
  import cfg_loader_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              par_mode,
  input  logic [TSEL_W-1:0] tsel,
  input  logic              sdata,
  input  logic              fbdiv,
  output logic              test_q
);

  always_ff @(posedge clk) begin
    if (rst || par_mode) begin
      test_q <= 1'b0;
    end else begin
      case (tsel_e'(tsel))
        TSEL_SDATA: test_q <= sdata;
        TSEL_FBDIV: test_q <= fbdiv;
        default:    test_q <= 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/clk_cfg_loader.sv
module clk_cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int M_W         = 9,
  parameter int N_W         = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           par_load_n,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  input  logic           ser_clk,
  input  logic           ser_data,
  input  logic           ser_load,
  input  logic           fb_div,
  output logic [M_W-1:0] m_out,
  output logic [N_W-1:0] n_out,
  output logic           test_out
);

  localparam int FW = TSEL_W + N_W + M_W;
  localparam int SW = 5 + N_W + M_W;

  logic [SW-1:0] raw_bus, sync_bus;
  logic          pl_s, sl_s, sc_s, sd_s, fb_s;
  logic [N_W-1:0] n_s;
  logic [M_W-1:0] m_s;
  logic          sc_p;
  logic          sc_rise;
  logic [FW-1:0] frame_nx;
  logic [TSEL_W-1:0] tsel_q;

  assign raw_bus = {par_load_n, ser_load, ser_clk, ser_data, fb_div, par_n, par_m};

  cfg_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .d_in   (raw_bus),
    .d_sync (sync_bus)
  );

  assign {pl_s, sl_s, sc_s, sd_s, fb_s, n_s, m_s} = sync_bus;

  always_ff @(posedge clk) begin
    if (rst) sc_p <= ser_clk;
    else     sc_p <= sc_s;
  end

  assign sc_rise = sc_s & ~sc_p;

  cfg_shift #(.FW(FW)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .shift_en (pl_s & sc_rise),
    .bit_in   (sd_s),
    .frame_nx (frame_nx)
  );

  cfg_regs #(.M_W(M_W), .N_W(N_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .rst_m    (par_m),
    .rst_n    (par_n),
    .par_mode (~pl_s),
    .ser_ld   (sl_s),
    .pin_m    (m_s),
    .pin_n    (n_s),
    .frame    (frame_nx),
    .m_q      (m_out),
    .n_q      (n_out),
    .tsel_q   (tsel_q)
  );

  cfg_test_mux u_test (
    .clk      (clk),
    .rst      (rst),
    .par_mode (~pl_s),
    .tsel     (tsel_q),
    .sdata    (sd_s),
    .fbdiv    (fb_s),
    .test_q   (test_out)
  );

endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
  parameter int M_W = 9,
  parameter int N_W = 3,
  parameter int FW  = 14
) (
  input logic           clk,
  input logic           rst,
  input logic           pl_s,
  input logic           sl_s,
  input logic [1:0]     tsel_q,
  input logic [FW-1:0]  frame_nx,
  input logic [M_W-1:0] m_s,
  input logic [N_W-1:0] n_s,
  input logic [M_W-1:0] m_out,
  input logic [N_W-1:0] n_out,
  input logic           test_out
);

  assert_rst_test_low_R1: assert property (@(posedge clk)
    rst |=> !test_out);

  assert_par_follow_R2: assert property (@(posedge clk) disable iff (rst)
    !pl_s |=> (m_out == $past(m_s) && n_out == $past(n_s)));

  assert_ser_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (pl_s && !sl_s) |=> $stable({m_out, n_out}));

  assert_ser_pass_R7: assert property (@(posedge clk) disable iff (rst)
    (pl_s && sl_s) |=> (m_out == $past(frame_nx[M_W-1:0])));

  assert_tsel_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (pl_s && (tsel_q == 2'b00 || tsel_q == 2'b11)) |=> !test_out);

  assert_par_test_low_R9: assert property (@(posedge clk) disable iff (rst)
    !pl_s |=> !test_out);

endmodule

bind clk_cfg_loader cfg_loader_chk #(
  .M_W (M_W),
  .N_W (N_W),
  .FW  (FW)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pl_s     (pl_s),
  .sl_s     (sl_s),
  .tsel_q   (tsel_q),
  .frame_nx (frame_nx),
  .m_s      (m_s),
  .n_s      (n_s),
  .m_out    (m_out),
  .n_out    (n_out),
  .test_out (test_out)
);

// File: tb/tb_clk_cfg_loader.sv
`timescale 1ns/1ps
module tb_clk_cfg_loader;

  localparam int MW   = 9;
  localparam int NW   = 3;
  localparam int SYNC = 3;
  localparam int FW   = 2 + NW + MW;
  localparam int W    = SYNC + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic par_load_n = 1'b0;
  logic [MW-1:0] par_m = 9'd300;
  logic [NW-1:0] par_n = 3'd2;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0, fb_div = 1'b0;
  logic [MW-1:0] m_out;
  logic [NW-1:0] n_out;
  logic test_out;

  always #2.5 clk = ~clk;

  clk_cfg_loader #(.M_W(MW), .N_W(NW), .SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rst(rst), .par_load_n(par_load_n), .par_m(par_m), .par_n(par_n),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_load(ser_load), .fb_div(fb_div),
    .m_out(m_out), .n_out(n_out), .test_out(test_out)
  );

  int    checks = 0;
  int    errors = 0;
  string tag    = "R1";
  bit    done   = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Reference model: a history queue of sampled pins, delayed by SYNC
  typedef struct packed {
    logic pl, sl, sc, sd, fb;
    logic [NW-1:0] n;
    logic [MW-1:0] m;
  } samp_t;

  samp_t         hist[$];
  logic [MW-1:0] em;
  logic [NW-1:0] en;
  logic [1:0]    et;
  logic [FW-1:0] esr;
  logic          etest;
  bit            mdl_ok = 1'b0;

  always @(posedge clk) begin
    samp_t now, cur, prv;
    logic [FW-1:0] nx;
    now = samp_t'({par_load_n, ser_load, ser_clk, ser_data, fb_div, par_n, par_m});
    if (rst) begin
      hist.delete();
      for (int i = 0; i <= SYNC; i++) hist.push_back(now);
      em = par_m; en = par_n; et = 2'b00; esr = '0; etest = 1'b0;
      mdl_ok = 1'b1;
    end else begin
      cur = hist[SYNC-1];
      prv = hist[SYNC];
      nx  = esr;
      if (cur.pl && cur.sc && !prv.sc) nx = {esr[FW-2:0], cur.sd};
      if (!cur.pl)         etest = 1'b0;
      else if (et == 2'd1) etest = cur.sd;
      else if (et == 2'd2) etest = cur.fb;
      else                 etest = 1'b0;
      if (!cur.pl) begin
        em = cur.m; en = cur.n;
      end else if (cur.sl) begin
        et = nx[FW-1:FW-2]; en = nx[MW+NW-1:MW]; em = nx[MW-1:0];
      end
      esr = nx;
      hist.push_front(now);
      void'(hist.pop_back());
    end
    #1;
    if (mdl_ok && !done) begin
      chk(m_out === em, tag, "model m_out", int'(m_out), int'(em));
      chk(n_out === en, tag, "model n_out", int'(n_out), int'(en));
      chk(test_out === etest, tag, "model test_out", int'(test_out), int'(etest));
    end
  end

  task automatic wait_n(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic expect_out(input string req, input int m, input int n, input int t);
    chk(m_out === MW'(m), req, "m_out", int'(m_out), m);
    chk(n_out === NW'(n), req, "n_out", int'(n_out), n);
    chk(test_out === 1'(t), req, "test_out", int'(test_out), t);
  endtask

  task automatic send_bit(input logic b);
    ser_data = b;  wait_n(W);
    ser_clk  = 1'b1; wait_n(W);
    ser_clk  = 1'b0; wait_n(W);
  endtask

  // R4 frame order: selector bit1, bit0, n2..n0, m8..m0
  task automatic send_frame(input logic [1:0] t, input logic [NW-1:0] n,
                            input logic [MW-1:0] m);
    logic [FW-1:0] v;
    v = {t, n, m};
    for (int i = FW - 1; i >= 0; i--) send_bit(v[i]);
    ser_data = 1'b0; wait_n(W);
  endtask

  task automatic pulse_load();
    ser_load = 1'b1; wait_n(W);
    ser_load = 1'b0; wait_n(W);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    wait_n(4);
    rst = 1'b0;
    wait_n(1);
    tag = "R1"; expect_out("R1", 300, 2, 0);

    tag = "R2"; par_m = 9'd400; par_n = 3'd5; wait_n(W);
    expect_out("R2", 400, 5, 0);

    tag = "R11"; send_frame(2'b10, 3'd6, 9'd85);   // ignored: parallel mode

    tag = "R3"; par_load_n = 1'b1; wait_n(W);
    par_m = 9'd123; par_n = 3'd7; wait_n(W);
    expect_out("R3", 400, 5, 0);

    tag = "R11"; pulse_load();                      // register never shifted
    expect_out("R11", 0, 0, 0);

    tag = "R4"; send_frame(2'b01, 3'd3, 9'd257);
    expect_out("R6", 0, 0, 0);
    pulse_load();
    expect_out("R4", 257, 3, 0);
    expect_out("R5", 257, 3, 0);

    tag = "R8"; ser_data = 1'b1; wait_n(W);
    expect_out("R8", 257, 3, 1);                    // selector 01 -> ser_data
    ser_data = 1'b0; wait_n(W);
    expect_out("R8", 257, 3, 0);

    tag = "R6"; send_frame(2'b10, 3'd6, 9'd85);
    expect_out("R6", 257, 3, 0);
    tag = "R5"; pulse_load();
    expect_out("R5", 85, 6, 0);
    tag = "R8"; fb_div = 1'b1; wait_n(W);
    expect_out("R8", 85, 6, 1);                     // selector 10 -> fb_div
    fb_div = 1'b0; wait_n(W);
    expect_out("R8", 85, 6, 0);

    tag = "R9"; fb_div = 1'b1; par_load_n = 1'b0; wait_n(W);
    expect_out("R9", 123, 7, 0);
    expect_out("R10", 123, 7, 0);
    par_load_n = 1'b1; wait_n(W);
    expect_out("R3", 123, 7, 1);                    // selector kept as 10
    fb_div = 1'b0; wait_n(W);

    tag = "R7"; ser_load = 1'b1; wait_n(W);
    send_frame(2'b11, 3'd1, 9'd511);
    expect_out("R7", 511, 1, 0);
    fb_div = 1'b1; ser_data = 1'b1; wait_n(W);
    expect_out("R8", 511, 1, 0);                    // reserved 11 -> low
    fb_div = 1'b0;
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    ser_data = 1'b0; wait_n(W);
    expect_out("R7", 509, 7, 0);                    // selector now 01
    ser_load = 1'b0; wait_n(W);

    tag = "R8"; send_frame(2'b00, 3'd4, 9'd77);
    pulse_load();
    fb_div = 1'b1; ser_data = 1'b1; wait_n(W);
    expect_out("R8", 77, 4, 0);                     // selector 00 -> low
    fb_div = 1'b0; ser_data = 1'b0; wait_n(W);

    finish_run();
  end

endmodule